// File: doc/BRIEF.md
# Cache Performance Monitor Counters

This block gathers usage statistics for a cache that has an instruction side and a data side. Each side sends four kinds of one-cycle event strobes: an access, a tag lookup, a hit that a lookup found, and a hit served from the line buffer. Each side has four counters, so there are eight counters in all. While the monitor is enabled, every strobe adds one to its counter. A hit from the line buffer also counts as an access, but it never counts as a tag lookup.

A small control state machine records the monitor enable. It has two states, `ST_PAUSED` and `ST_COUNTING`. The *arm* transition (`ST_PAUSED` to `ST_COUNTING`) happens on a clock edge where the enable is high. The *pause* transition (`ST_COUNTING` to `ST_PAUSED`) happens on an edge where the enable is low. Counting occurs only in `ST_COUNTING`. Pausing keeps every count. A one-cycle clear command sets all eight counters to zero in any state. Software can also load any counter directly.

A registered read port returns a counter value one cycle after a read request. The counter address has two fields. Bit 2 selects the side: 0 is data, 1 is instruction. Bits 1:0 select the kind: 0 access, 1 lookup, 2 lookup hit, 3 line-buffer hit.

Top module: `perf_monitor`

## Requirements
- R1: After reset, all eight counters are 0, `rd_valid` is 0, `rd_data` is 0 and the controller is in `ST_PAUSED`.
- R2: In `ST_COUNTING`, each asserted strobe adds exactly one to its counter. The access counter of a side adds one when that side's access strobe or line-hit strobe (or both) is high.
- R3: A line-buffer hit strobe adds one to the access counter and the line-hit counter of its side. It never changes the tag-lookup counter.
- R4: In `ST_PAUSED`, strobes have no effect, and each counter keeps its value unless it is cleared or written.
- R5: `clr_stats` high at a clock edge sets all eight counters to 0 at that edge, whatever the state. It takes priority over a direct write and over an event in the same cycle.
- R6: `wr_en` high at an edge loads `wr_data` into the counter selected by `wr_addr` (encoding as in R8). This takes priority over an increment of that counter in the same cycle.
- R7: Counters wrap modulo 2^CNT_W with no saturation: an increment from all-ones gives 0.
- R8: `rd_en` high at an edge with `rd_addr` = {side, kind} places that counter's value from before the edge on `rd_data`, with `rd_valid` high in the following cycle. Side 0 is data and side 1 is instruction. Kind 0 is access, 1 tag lookup, 2 lookup hit, 3 line-buffer hit. When `rd_en` is low, `rd_valid` goes low and `rd_data` holds its value.
- R9: The controller state follows `mon_en` with one cycle of latency. A strobe counts only if `mon_en` was high at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_en | input | 1 | Monitor enable |
| clr_stats | input | 1 | One-cycle command to clear all counters |
| d_access | input | 1 | Data-side access strobe |
| d_lookup | input | 1 | Data-side tag lookup strobe |
| d_hit | input | 1 | Data-side lookup hit strobe |
| d_line_hit | input | 1 | Data-side line-buffer hit strobe |
| i_access | input | 1 | Instruction-side access strobe |
| i_lookup | input | 1 | Instruction-side tag lookup strobe |
| i_hit | input | 1 | Instruction-side lookup hit strobe |
| i_line_hit | input | 1 | Instruction-side line-buffer hit strobe |
| wr_en | input | 1 | Direct counter write |
| wr_addr | input | 3 | Counter index for the write |
| wr_data | input | CNT_W | Value to load |
| rd_en | input | 1 | Read request |
| rd_addr | input | 3 | Counter index for the read |
| rd_data | output | CNT_W | Read data, valid the cycle after the request |
| rd_valid | output | 1 | Read data valid |

## Verification
If a counter's state is wrong, it shows on `rd_data` the first time that counter is read: one cycle after the request that names it. The bench requests a different counter on almost every cycle, rotating through all eight, so a wrong increment, a missed clear or a misrouted write appears within about eight cycles of the fault. If the controller state is wrong, a count appears while paused or is missing while enabled. That error stays in the counter and is seen at the counter's next read.

// File: rtl/perf_mon_pkg.sv
package perf_mon_pkg;

    localparam int KINDS_PER_SIDE = 4;
    localparam int NUM_SIDES      = 2;
    localparam int NUM_CNT        = KINDS_PER_SIDE * NUM_SIDES;
    localparam int KIND_W         = $clog2(KINDS_PER_SIDE);
    localparam int CNT_ADDR_W     = $clog2(NUM_CNT);

    typedef enum logic [KIND_W-1:0] {
        KIND_ACCESS = 2'd0,
        KIND_LOOKUP = 2'd1,
        KIND_HIT    = 2'd2,
        KIND_LINE   = 2'd3
    } cnt_kind_e;

    typedef enum logic {
        SIDE_DATA  = 1'b0,
        SIDE_INSTR = 1'b1
    } side_e;

    typedef enum logic {
        ST_PAUSED   = 1'b0,
        ST_COUNTING = 1'b1
    } mon_state_e;

    typedef struct packed {
        logic access;
        logic lookup;
        logic hit;
        logic line_hit;
    } side_ev_t;

endpackage

// File: rtl/perf_mon_ctrl.sv
module perf_mon_ctrl
    import perf_mon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mon_en,
    output logic cnt_active
);

    mon_state_e state_q;
    mon_state_e state_d;

    // Next state: arm on enable, pause when enable drops.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PAUSED:   if (mon_en)  state_d = ST_COUNTING;
            ST_COUNTING: if (!mon_en) state_d = ST_PAUSED;
            default:                  state_d = ST_PAUSED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PAUSED;
        else        state_q <= state_d;
    end

    always_comb begin
        cnt_active = (state_q == ST_COUNTING);
    end

endmodule

// File: rtl/perf_mon_counter.sv
module perf_mon_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             inc,
    output logic [CNT_W-1:0] q
);

    // Priority: clear, then direct load, then increment (wraps).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (clr) q <= '0;
        else if (wr)  q <= wdata;
        else if (inc) q <= q + CNT_W'(1);
    end

endmodule

// File: rtl/perf_mon_side.sv
module perf_mon_side
    import perf_mon_pkg::*;
#(
    parameter int    CNT_W = 32,
    parameter side_e SIDE  = SIDE_DATA
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  side_ev_t                        ev,
    input  logic                            count_en,
    input  logic                            clr,
    input  logic                            wr_en,
    input  logic [CNT_ADDR_W-1:0]           wr_addr,
    input  logic [CNT_W-1:0]                wr_data,
    output logic [KINDS_PER_SIDE*CNT_W-1:0] cnt_flat
);

    logic [KINDS_PER_SIDE-1:0] inc_vec;
    logic                      side_sel;

    // Line-buffer hits are accesses too, but never tag lookups.
    always_comb begin
        inc_vec              = '0;
        inc_vec[KIND_ACCESS] = count_en & (ev.access | ev.line_hit);
        inc_vec[KIND_LOOKUP] = count_en & ev.lookup;
        inc_vec[KIND_HIT]    = count_en & ev.hit;
        inc_vec[KIND_LINE]   = count_en & ev.line_hit;
    end

    always_comb begin
        side_sel = (side_e'(wr_addr[CNT_ADDR_W-1]) == SIDE);
    end

    for (genvar k = 0; k < KINDS_PER_SIDE; k++) begin : g_cnt
        logic wr_k;
        always_comb begin
            wr_k = wr_en & side_sel & (wr_addr[KIND_W-1:0] == KIND_W'(k));
        end
        perf_mon_counter #(.CNT_W(CNT_W)) u_counter (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .wr    (wr_k),
            .wdata (wr_data),
            .inc   (inc_vec[k]),
            .q     (cnt_flat[k*CNT_W +: CNT_W])
        );
    end

endmodule

// File: rtl/perf_mon_readport.sv
module perf_mon_readport #(
    parameter int CNT_W = 32,
    parameter int NUM   = 8,
    parameter int AW    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic [AW-1:0]        rd_addr,
    input  logic [NUM*CNT_W-1:0] cnt_flat,
    output logic [CNT_W-1:0]     rd_data,
    output logic                 rd_valid
);

    logic [CNT_W-1:0] cnt_arr [NUM];

    for (genvar n = 0; n < NUM; n++) begin : g_unpack
        assign cnt_arr[n] = cnt_flat[n*CNT_W +: CNT_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= cnt_arr[rd_addr];
        end
    end

endmodule

// File: rtl/perf_monitor.sv
module perf_monitor
    import perf_mon_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mon_en,
    input  logic                  clr_stats,
    input  logic                  d_access,
    input  logic                  d_lookup,
    input  logic                  d_hit,
    input  logic                  d_line_hit,
    input  logic                  i_access,
    input  logic                  i_lookup,
    input  logic                  i_hit,
    input  logic                  i_line_hit,
    input  logic                  wr_en,
    input  logic [CNT_ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]      wr_data,
    input  logic                  rd_en,
    input  logic [CNT_ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]      rd_data,
    output logic                  rd_valid
);

    localparam int SIDE_BITS = KINDS_PER_SIDE * CNT_W;

    logic                     cnt_active;
    logic [NUM_CNT*CNT_W-1:0] cnt_flat;
    side_ev_t                 ev_side [NUM_SIDES];

    always_comb begin
        ev_side[SIDE_DATA]  = '{access: d_access, lookup: d_lookup,
                                hit: d_hit, line_hit: d_line_hit};
        ev_side[SIDE_INSTR] = '{access: i_access, lookup: i_lookup,
                                hit: i_hit, line_hit: i_line_hit};
    end

    perf_mon_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mon_en     (mon_en),
        .cnt_active (cnt_active)
    );

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        perf_mon_side #(
            .CNT_W (CNT_W),
            .SIDE  (side_e'(s))
        ) u_side (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev       (ev_side[s]),
            .count_en (cnt_active),
            .clr      (clr_stats),
            .wr_en    (wr_en),
            .wr_addr  (wr_addr),
            .wr_data  (wr_data),
            .cnt_flat (cnt_flat[s*SIDE_BITS +: SIDE_BITS])
        );
    end

    perf_mon_readport #(
        .CNT_W (CNT_W),
        .NUM   (NUM_CNT),
        .AW    (CNT_ADDR_W)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .cnt_flat (cnt_flat),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

endmodule

// File: rtl/perf_monitor_chk.sv
module perf_monitor_chk
    import perf_mon_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     mon_en,
    input logic                     clr_stats,
    input logic                     d_lookup,
    input logic                     d_line_hit,
    input logic                     wr_en,
    input logic [CNT_ADDR_W-1:0]    wr_addr,
    input logic [CNT_W-1:0]         wr_data,
    input logic                     rd_en,
    input logic [CNT_W-1:0]         rd_data,
    input logic                     rd_valid,
    input logic                     cnt_active,
    input logic [NUM_CNT*CNT_W-1:0] cnt_flat
);

    logic [CNT_W-1:0]      chk_arr [NUM_CNT];
    logic                  wr_seen;
    logic [CNT_ADDR_W-1:0] wr_idx_q;
    logic [CNT_W-1:0]      wr_val_q;
    logic                  d_lookup_wr;

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_unpack
        assign chk_arr[n] = cnt_flat[n*CNT_W +: CNT_W];
    end

    assign d_lookup_wr = wr_en && (wr_addr == CNT_ADDR_W'(KIND_LOOKUP));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_seen  <= 1'b0;
            wr_idx_q <= '0;
            wr_val_q <= '0;
        end else begin
            wr_seen  <= wr_en && !clr_stats;
            wr_idx_q <= wr_addr;
            wr_val_q <= wr_data;
        end
    end

    AST_RD_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R8
    AST_RD_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!rd_valid && $stable(rd_data))); // R8
    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stats |=> (cnt_flat == '0)); // R5
    AST_STATE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        mon_en |=> cnt_active); // R9
    AST_STATE_PAUSES: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en |=> !cnt_active); // R9
    AST_FROZEN_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_active && !clr_stats && !wr_en) |=> $stable(cnt_flat)); // R4
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_seen |-> (chk_arr[wr_idx_q] == wr_val_q)); // R6
    AST_LINE_NOT_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_active && d_line_hit && !d_lookup && !clr_stats && !d_lookup_wr)
        |=> $stable(chk_arr[KIND_LOOKUP])); // R3

endmodule

bind perf_monitor perf_monitor_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mon_en     (mon_en),
    .clr_stats  (clr_stats),
    .d_lookup   (d_lookup),
    .d_line_hit (d_line_hit),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .cnt_active (cnt_active),
    .cnt_flat   (cnt_flat)
);

// File: tb/perf_monitor_tb.sv
module perf_monitor_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 32;
    localparam int NCNT       = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mon_en = 1'b0, clr_stats = 1'b0;
    logic             d_access = 1'b0, d_lookup = 1'b0, d_hit = 1'b0, d_line_hit = 1'b0;
    logic             i_access = 1'b0, i_lookup = 1'b0, i_hit = 1'b0, i_line_hit = 1'b0;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_addr = '0;
    logic [CNT_W-1:0] wr_data = '0;
    logic             rd_en = 1'b0;
    logic [2:0]       rd_addr = '0;
    logic [CNT_W-1:0] rd_data;
    logic             rd_valid;

    perf_monitor #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .clr_stats(clr_stats),
        .d_access(d_access), .d_lookup(d_lookup), .d_hit(d_hit), .d_line_hit(d_line_hit),
        .i_access(i_access), .i_lookup(i_lookup), .i_hit(i_hit), .i_line_hit(i_line_hit),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    checks = 0;
    int    failures = 0;
    string req_tag = "R1";
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;
    int    rot = 0;

    // Behavioural reference model, updated at each rising edge.
    logic [CNT_W-1:0] m_cnt [NCNT];
    logic [CNT_W-1:0] m_rd_data;
    bit               m_rd_valid;
    bit               m_active;

    always @(posedge clk) begin
        bit inc [NCNT];
        if (!rst_n) begin
            for (int i = 0; i < NCNT; i++) m_cnt[i] = '0;
            m_rd_data  = '0;
            m_rd_valid = 1'b0;
            m_active   = 1'b0;
        end else begin
            if (rd_en) m_rd_data = m_cnt[rd_addr];
            m_rd_valid = rd_en;
            inc[0] = d_access | d_line_hit;
            inc[1] = d_lookup;
            inc[2] = d_hit;
            inc[3] = d_line_hit;
            inc[4] = i_access | i_line_hit;
            inc[5] = i_lookup;
            inc[6] = i_hit;
            inc[7] = i_line_hit;
            for (int i = 0; i < NCNT; i++) begin
                if (clr_stats)                   m_cnt[i] = '0;
                else if (wr_en && wr_addr == i)  m_cnt[i] = wr_data;
                else if (m_active && inc[i])     m_cnt[i] = m_cnt[i] + 1;
            end
            m_active = mon_en;
        end
    end

    task automatic check(string tag, string what, logic [CNT_W-1:0] act, logic [CNT_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        if (cmp_on) begin
            check(req_tag, "rd_valid", CNT_W'(rd_valid), CNT_W'(m_rd_valid));
            check(req_tag, "rd_data", rd_data, m_rd_data);
        end
    endtask

    task automatic quiet();
        {d_access, d_lookup, d_hit, d_line_hit} = '0;
        {i_access, i_lookup, i_hit, i_line_hit} = '0;
        wr_en = 1'b0;
        clr_stats = 1'b0;
    endtask

    task automatic next_read(bit on);
        rd_en = on;
        rd_addr = 3'(rot);
        rot++;
    endtask

    task automatic run(int n, bit line_only, bit allow_wr, bit allow_clr, bit rd_on);
        for (int c = 0; c < n; c++) begin
            quiet();
            if (line_only) begin
                d_line_hit = 1'($urandom_range(0, 1));
                i_line_hit = 1'($urandom_range(0, 1));
            end else begin
                {d_access, d_lookup, d_hit, d_line_hit} = 4'($urandom_range(0, 15));
                {i_access, i_lookup, i_hit, i_line_hit} = 4'($urandom_range(0, 15));
            end
            if (allow_wr && $urandom_range(0, 3) == 0) begin
                wr_en   = 1'b1;
                wr_addr = 3'($urandom_range(0, 7));
                wr_data = (c % 2 == 0) ? 32'hFFFF_FFFE + 32'($urandom_range(0, 1))
                                       : 32'($urandom_range(0, 1000));
            end
            if (allow_clr && $urandom_range(0, 9) == 0) clr_stats = 1'b1;
            next_read(rd_on ? 1'b1 : 1'($urandom_range(0, 1)));
            cyc();
        end
        quiet();
    endtask

    initial begin
        // R1: reset state seen at the read port.
        repeat (3) @(negedge clk);
        checks++;
        if (rd_valid !== 1'b0 || rd_data !== '0) begin
            failures++;
            $display("FAIL R1 reset outputs: actual %b/%h expected 0/0", rd_valid, rd_data);
        end
        rst_n = 1'b1;
        cmp_on = 1'b1;
        req_tag = "R1";
        for (int a = 0; a < NCNT; a++) begin
            next_read(1'b1);
            cyc();
        end
        // R4: events while never enabled leave counters at zero.
        req_tag = "R4";
        run(24, 1'b0, 1'b0, 1'b0, 1'b1);
        // R9: enable toggles, one-cycle latency.
        req_tag = "R9";
        for (int t = 0; t < 6; t++) begin
            mon_en = ~mon_en;
            run(5, 1'b0, 1'b0, 1'b0, 1'b1);
        end
        // R2: counting under mixed strobe patterns.
        req_tag = "R2";
        mon_en = 1'b1;
        run(160, 1'b0, 1'b0, 1'b0, 1'b1);
        // R3: line-buffer hits only.
        req_tag = "R3";
        run(40, 1'b1, 1'b0, 1'b0, 1'b1);
        // R4: paused counts stay frozen.
        req_tag = "R4";
        mon_en = 1'b0;
        run(40, 1'b0, 1'b0, 1'b0, 1'b1);
        // R5: clear while paused, then while counting with writes and events.
        req_tag = "R5";
        clr_stats = 1'b1;
        next_read(1'b1);
        cyc();
        quiet();
        run(16, 1'b0, 1'b0, 1'b0, 1'b1);
        mon_en = 1'b1;
        run(120, 1'b0, 1'b1, 1'b1, 1'b1);
        // R6: direct writes racing increments.
        req_tag = "R6";
        run(120, 1'b0, 1'b1, 1'b0, 1'b1);
        // R7: directed wrap of the instruction access counter (index 4).
        req_tag = "R7";
        quiet();
        wr_en = 1'b1; wr_addr = 3'd4; wr_data = 32'hFFFF_FFFF;
        rd_en = 1'b0;
        cyc();
        quiet();
        i_access = 1'b1;
        cyc();
        quiet();
        rd_en = 1'b1; rd_addr = 3'd4;
        cyc();
        check("R7", "wrapped count", rd_data, 32'h0);
        run(60, 1'b0, 1'b1, 1'b0, 1'b1);
        // R8: sparse reads, data must hold between them.
        req_tag = "R8";
        run(80, 1'b0, 1'b1, 1'b1, 1'b0);
        rd_en = 1'b0;
        cyc();
        cyc();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule